// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit takes two floating-point operands, both single precision or both double precision as chosen by a precision input, and compares them quietly. The comparison settles on exactly one relation: less, equal, greater or unordered. A 3-bit predicate code then reduces that relation to a single condition flag. The unit also receives the current 32-bit floating-point status/control word and returns a copy with the flag written into its top nibble.

Requests enter on a valid/ready channel and carry the operands, the precision select, the predicate code and the status word. The response sits in an output register and leaves on its own valid/ready channel. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so one request per cycle flows through when `out_ready` stays high. While `out_valid` is high and `out_ready` is low, the response is held unchanged and no new request is accepted.

Top module: `fpcc_unit`

## Requirements
- R1: The predicate code selects which relations set the flag. 0 never sets it. 1 sets it on unordered. 2 on equal. 3 on unordered or equal. 4 on less. 5 on unordered or less. 6 on less or equal. 7 on unordered, less or equal (anything but greater).
- R2: An operand with an all-ones exponent and a nonzero fraction is a NaN. If either operand is a NaN, the relation is unordered.
- R3: Positive zero and negative zero compare equal, in both orders and in both precisions.
- R4: Non-NaN values are ordered by sign first and then by the magnitude of the exponent and fraction bits. For two negative values the magnitude order is reversed. Infinities fall into this order as the largest magnitudes.
- R5: With `in_dbl`=0 only bits 31:0 of each operand are used (sign 31, exponent 30:23, fraction 22:0), and bits 63:32 have no effect on the response. With `in_dbl`=1 all 64 bits are used (sign 63, exponent 62:52, fraction 51:0), and the predicate meanings are the same as in single precision.
- R6: Bit 29 of `out_status` equals `out_flag`. Bits 31, 30 and 28 of `out_status` are zero.
- R7: Bits 27:0 of `out_status` equal bits 27:0 of the accepted `in_status`.
- R8: `out_invalid` is high in a response exactly when at least one operand is a signaling NaN (a NaN whose fraction MSB is clear). Quiet NaNs leave it low.
- R9: A request accepted at a clock edge appears on the outputs with `out_valid` high right after that edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_flag`, `out_status` and `out_invalid` hold their values. A request offered during the stall is accepted at the edge where the stalled response drains.
- R11: A clock edge with `rst_n` low clears `out_valid`, `out_flag`, `out_status` and `out_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_a | input | 64 | First operand (low 32 bits in single precision) |
| in_b | input | 64 | Second operand (low 32 bits in single precision) |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_pred | input | 3 | Predicate code |
| in_status | input | 32 | Status/control word to update |
| out_valid | output | 1 | Response valid |
| out_ready | input | 1 | Consumer accepts the response |
| out_flag | output | 1 | Condition flag |
| out_status | output | 32 | Updated status word |
| out_invalid | output | 1 | A signaling NaN was seen in this response |

## Verification
The assertions assume a consumer that follows the handshake, so inputs are only sampled on an accepting edge, and a reset held long enough for one clock edge before traffic begins. The stimulus changes inputs only between edges. It lowers `in_valid` after each transfer, except in the back-pressure sequence, where a second request is held steady through the stall. Random operands are biased toward zeros, infinities, quiet and signaling NaNs and equal pairs, so that every relation and every predicate code is exercised. Single-precision vectors carry random data in the unused upper operand bits.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef enum logic [2:0] {
    PC_NEVER = 3'd0,
    PC_UN    = 3'd1,
    PC_EQ    = 3'd2,
    PC_UEQ   = 3'd3,
    PC_OLT   = 3'd4,
    PC_ULT   = 3'd5,
    PC_OLE   = 3'd6,
    PC_ULE   = 3'd7
  } pcode_e;
endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic [W-1:0] op,
  output logic         sign,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero,
  output logic [W-2:0] mag
);
  localparam int FRAC_W = W - EXP_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign    = op[W-1];
  assign mag     = op[W-2:0];
  assign exp_f   = op[W-2:FRAC_W];
  assign frac_f  = op[FRAC_W-1:0];
  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_snan = is_nan && !frac_f[FRAC_W-1];
  assign is_zero = (mag == '0);
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             a_sign,
  input  logic             a_nan,
  input  logic             a_zero,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic             b_nan,
  input  logic             b_zero,
  input  logic [MAG_W-1:0] b_mag,
  output rel_e             rel
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = (a_mag < b_mag);
  assign mag_eq = (a_mag == b_mag);

  always_comb begin
    if (a_nan || b_nan) begin
      rel = REL_UN;
    end else if (a_zero && b_zero) begin
      rel = REL_EQ;
    end else if (a_sign != b_sign) begin
      rel = a_sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else begin
      rel = (mag_lt ^ a_sign) ? REL_LT : REL_GT;
    end
  end
endmodule

// File: rtl/fpcc_predicate.sv
module fpcc_predicate
  import fpcc_pkg::*;
(
  input  rel_e       rel,
  input  logic [2:0] code,
  output logic       flag
);
  logic r_un, r_eq, r_lt;

  assign r_un = (rel == REL_UN);
  assign r_eq = (rel == REL_EQ);
  assign r_lt = (rel == REL_LT);

  always_comb begin
    flag = 1'b0;
    unique case (pcode_e'(code))
      PC_NEVER: flag = 1'b0;
      PC_UN:    flag = r_un;
      PC_EQ:    flag = r_eq;
      PC_UEQ:   flag = r_un | r_eq;
      PC_OLT:   flag = r_lt;
      PC_ULT:   flag = r_un | r_lt;
      PC_OLE:   flag = r_lt | r_eq;
      PC_ULE:   flag = r_un | r_lt | r_eq;
      default:  flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int SGL_W    = 32,
  parameter int SGL_EXP  = 8,
  parameter int DBL_W    = 64,
  parameter int DBL_EXP  = 11,
  parameter int STAT_W   = 32,
  parameter int FLAG_POS = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DBL_W-1:0]  in_a,
  input  logic [DBL_W-1:0]  in_b,
  input  logic              in_dbl,
  input  logic [2:0]        in_pred,
  input  logic [STAT_W-1:0] in_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_flag,
  output logic [STAT_W-1:0] out_status,
  output logic              out_invalid
);
  localparam int KEEP_W = FLAG_POS - 1;
  localparam int MAG_W  = DBL_W - 1;
  localparam int SMAG_W = SGL_W - 1;

  // per-operand, per-format classification
  logic             s_sign [2];
  logic             s_nan  [2];
  logic             s_snan [2];
  logic             s_zero [2];
  logic [SMAG_W-1:0] s_mag [2];
  logic             d_sign [2];
  logic             d_nan  [2];
  logic             d_snan [2];
  logic             d_zero [2];
  logic [MAG_W-1:0] d_mag  [2];

  logic             c_sign [2];
  logic             c_nan  [2];
  logic             c_snan [2];
  logic             c_zero [2];
  logic [MAG_W-1:0] c_mag  [2];

  logic [DBL_W-1:0] ops [2];
  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
    fpcc_classify #(.W(SGL_W), .EXP_W(SGL_EXP)) u_sgl (
      .op      (ops[gi][SGL_W-1:0]),
      .sign    (s_sign[gi]),
      .is_nan  (s_nan[gi]),
      .is_snan (s_snan[gi]),
      .is_zero (s_zero[gi]),
      .mag     (s_mag[gi])
    );
    fpcc_classify #(.W(DBL_W), .EXP_W(DBL_EXP)) u_dbl (
      .op      (ops[gi]),
      .sign    (d_sign[gi]),
      .is_nan  (d_nan[gi]),
      .is_snan (d_snan[gi]),
      .is_zero (d_zero[gi]),
      .mag     (d_mag[gi])
    );
    assign c_sign[gi] = in_dbl ? d_sign[gi] : s_sign[gi];
    assign c_nan[gi]  = in_dbl ? d_nan[gi]  : s_nan[gi];
    assign c_snan[gi] = in_dbl ? d_snan[gi] : s_snan[gi];
    assign c_zero[gi] = in_dbl ? d_zero[gi] : s_zero[gi];
    assign c_mag[gi]  = in_dbl ? d_mag[gi]
                               : {{(MAG_W-SMAG_W){1'b0}}, s_mag[gi]};
  end

  rel_e rel_w;
  logic flag_w;
  logic snan_w;

  fpcc_order #(.MAG_W(MAG_W)) u_order (
    .a_sign (c_sign[0]),
    .a_nan  (c_nan[0]),
    .a_zero (c_zero[0]),
    .a_mag  (c_mag[0]),
    .b_sign (c_sign[1]),
    .b_nan  (c_nan[1]),
    .b_zero (c_zero[1]),
    .b_mag  (c_mag[1]),
    .rel    (rel_w)
  );

  fpcc_predicate u_pred (
    .rel  (rel_w),
    .code (in_pred),
    .flag (flag_w)
  );

  assign snan_w = c_snan[0] | c_snan[1];

  // status word assembly: low field kept, flag inserted, rest of top cleared
  logic              sig_unused_hi;
  logic [STAT_W-1:0] stat_w;
  assign sig_unused_hi = ^in_status[STAT_W-1:KEEP_W];

  always_comb begin
    stat_w               = '0;
    stat_w[KEEP_W-1:0]   = in_status[KEEP_W-1:0];
    stat_w[FLAG_POS]     = flag_w;
  end

  // output register with back-pressure
  logic in_fire;
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_flag    <= 1'b0;
      out_status  <= '0;
      out_invalid <= 1'b0;
    end else if (in_fire) begin
      out_valid   <= 1'b1;
      out_flag    <= flag_w;
      out_status  <= stat_w;
      out_invalid <= snan_w;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_pred == 3'd0 |=> !out_flag);                       // R1
  AST_SNAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    snan_w |-> rel_w == REL_UN);                                     // R2
  AST_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_status[FLAG_POS] == out_flag
      && out_status[STAT_W-1:FLAG_POS+1] == '0
      && out_status[FLAG_POS-1:KEEP_W] == '0);                       // R6
  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_status[KEEP_W-1:0] == $past(in_status[KEEP_W-1:0])); // R7
  AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);                                          // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_flag)
      && $stable(out_status) && $stable(out_invalid));               // R10
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !out_flag && !out_invalid);       // R11
endmodule

// File: tb/sim_fpcc_unit.sv
module sim_fpcc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        in_dbl = 1'b0;
  logic [2:0]  in_pred = '0;
  logic [31:0] in_status = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_flag;
  logic [31:0] out_status;
  logic        out_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fpcc_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_dbl(in_dbl), .in_pred(in_pred),
    .in_status(in_status), .out_valid(out_valid), .out_ready(out_ready),
    .out_flag(out_flag), .out_status(out_status), .out_invalid(out_invalid)
  );

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // ---- reference model ----
  function automatic bit m_nan(logic [63:0] x, bit dbl);
    return dbl ? (x[62:52] == 11'h7ff && x[51:0] != 0)
               : (x[30:23] == 8'hff && x[22:0] != 0);
  endfunction
  function automatic bit m_snan(logic [63:0] x, bit dbl);
    return m_nan(x, dbl) && !(dbl ? x[51] : x[22]);
  endfunction
  function automatic bit m_zero(logic [63:0] x, bit dbl);
    return dbl ? (x[62:0] == 0) : (x[30:0] == 0);
  endfunction
  function automatic logic [63:0] m_key(logic [63:0] x, bit dbl);
    logic        s = dbl ? x[63] : x[31];
    logic [62:0] m = dbl ? x[62:0] : {32'b0, x[30:0]};
    return s ? {1'b0, ~m} : {1'b1, m};
  endfunction
  // 0 lt, 1 eq, 2 gt, 3 un
  function automatic int m_rel(logic [63:0] a, logic [63:0] b, bit dbl);
    if (m_nan(a, dbl) || m_nan(b, dbl)) return 3;
    if (m_zero(a, dbl) && m_zero(b, dbl)) return 1;
    if (m_key(a, dbl) < m_key(b, dbl)) return 0;
    if (m_key(a, dbl) == m_key(b, dbl)) return 1;
    return 2;
  endfunction
  function automatic bit m_flag(int rel, logic [2:0] code);
    case (code)
      3'd0: return 0;
      3'd1: return rel == 3;
      3'd2: return rel == 1;
      3'd3: return rel == 3 || rel == 1;
      3'd4: return rel == 0;
      3'd5: return rel == 3 || rel == 0;
      3'd6: return rel == 0 || rel == 1;
      default: return rel != 2;
    endcase
  endfunction
  function automatic logic [34:0] m_rsp(logic [63:0] a, logic [63:0] b, bit dbl,
                                        logic [2:0] code, logic [31:0] st);
    bit f = m_flag(m_rel(a, b, dbl), code);
    bit iv = m_snan(a, dbl) || m_snan(b, dbl);
    return {1'b1, f, iv, 2'b00, f, 1'b0, st[27:0]};
  endfunction

  task automatic run_vec(logic [63:0] a, logic [63:0] b, bit dbl,
                         logic [2:0] code, logic [31:0] st, string req);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_dbl = dbl;
    in_pred = code; in_status = st; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {29'b0, out_valid, out_flag, out_invalid, out_status},
          {29'b0, m_rsp(a, b, dbl, code, st)});
  endtask

  function automatic logic [63:0] gen_op(bit dbl);
    int k = $urandom % 8;
    logic [63:0] r = {$urandom, $urandom};
    logic s = r[0];
    if (dbl) begin
      case (k)
        0: return {s, 63'b0};
        1: return {s, 11'h7ff, 52'b0};
        2: return {s, 11'h7ff, 1'b1, r[50:0]};
        3: return {s, 11'h7ff, 1'b0, r[50:1], 1'b1};
        default: return r;
      endcase
    end else begin
      case (k)
        0: return {r[63:32], s, 31'b0};
        1: return {r[63:32], s, 8'hff, 23'b0};
        2: return {r[63:32], s, 8'hff, 1'b1, r[21:0]};
        3: return {r[63:32], s, 8'hff, 1'b0, r[21:1], 1'b1};
        default: return r;
      endcase
    end
  endfunction

  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240613));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", {59'b0, out_valid, out_flag, out_invalid, in_ready, |out_status},
          64'h2);
    rst_n = 1'b1;

    // R1 all codes over every relation, double precision
    for (int c = 0; c < 8; c++) begin
      run_vec(D_ONE, D_TWO,  1'b1, 3'(c), 32'h0123_4567, "R1 lt");
      run_vec(D_TWO, D_ONE,  1'b1, 3'(c), 32'hF000_0001, "R1 gt");
      run_vec(D_ONE, D_ONE,  1'b1, 3'(c), 32'h0FFF_FFFF, "R1 eq");
      run_vec(D_QNAN, D_ONE, 1'b1, 3'(c), 32'hA5A5_A5A5, "R1 un");
    end
    // R2 NaN in either slot, single
    run_vec(64'h0, 64'h7FC0_0000, 1'b0, 3'd1, 32'h0, "R2 qnan b");
    run_vec(64'h7F80_0001, 64'h7F80_0001, 1'b0, 3'd2, 32'h0, "R2 same nan");
    // R3 signed zeros
    run_vec(64'h8000_0000, 64'h0, 1'b0, 3'd2, 32'h0, "R3 sgl -0 +0");
    run_vec(64'h0, 64'h8000_0000_0000_0000, 1'b1, 3'd2, 32'h0, "R3 dbl +0 -0");
    // R4 negatives and infinities
    run_vec(D_MTWO, D_MONE, 1'b1, 3'd4, 32'h0, "R4 -2<-1");
    run_vec(D_MONE, D_TWO, 1'b1, 3'd4, 32'h0, "R4 sign");
    run_vec(64'hFFF0_0000_0000_0000, D_MTWO, 1'b1, 3'd4, 32'h0, "R4 -inf");
    run_vec(64'h7F80_0000, 64'h7F7F_FFFF, 1'b0, 3'd6, 32'h0, "R4 +inf");
    // R5 upper bits ignored in single
    run_vec(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_3F80_0000, 1'b0, 3'd2, 32'h0,
            "R5 upper ignored");
    // R8 signaling vs quiet
    run_vec(D_SNAN, D_ONE, 1'b1, 3'd1, 32'h0, "R8 snan");
    run_vec(D_ONE, D_QNAN, 1'b1, 3'd1, 32'h0, "R8 qnan");
    run_vec(64'h0, 64'h7F80_0001, 1'b0, 3'd0, 32'h0, "R8 sgl snan");
    // R6 R7 status word
    run_vec(D_ONE, D_ONE, 1'b1, 3'd2, 32'hFFFF_FFFF, "R6 R7 set");
    run_vec(D_ONE, D_ONE, 1'b1, 3'd0, 32'hFFFF_FFFF, "R6 R7 clear");

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    in_a = D_MONE; in_b = D_ONE; in_dbl = 1'b1; in_pred = 3'd4; in_status = 32'h1234_5678;
    @(negedge clk);
    // second request offered during stall
    in_a = D_QNAN; in_b = D_ONE; in_pred = 3'd1; in_status = 32'h0000_00AA;
    repeat (3) begin
      check("R10 stall hold", {58'b0, in_ready, out_valid, out_flag, out_invalid, out_status[29:28]},
            {58'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10});
      check("R10 stall status", {32'b0, out_status}, {32'b0, 32'h2234_5678});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second accepted", {29'b0, out_valid, out_flag, out_invalid, out_status},
          {29'b0, m_rsp(D_QNAN, D_ONE, 1'b1, 3'd1, 32'h0000_00AA)});
    @(negedge clk);
    check("R9 drained", {63'b0, out_valid}, 64'h0);

    // random traffic: R1 R2 R3 R4 R5 R8 R9
    for (int i = 0; i < 600; i++) begin
      bit d = 1'($urandom);
      logic [63:0] a = gen_op(d);
      logic [63:0] b = ($urandom % 6 == 0) ? a : gen_op(d);
      if ($urandom % 8 == 0) b = {b[63:32], b[31:0] ^ 32'h8000_0000};
      run_vec(a, b, d, 3'($urandom), $urandom, "R1 R4 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule